// File: doc/BRIEF.md
# Zero-Voltage-Switching Gate Sequencer

This block sequences the two power switches of a synchronous step-down stage. It produces a phase signal from a 6-bit duty code and an externally chosen period. It turns each switch on only after the switching node has swung, so that the switch closes with little voltage across it. The period is split into 64 equal slots, each lasting `stepDiv+1` clocks. `pwmPhase` is low during the first `dutyCode` slots, which form the high-side interval, and high for the remaining slots, which form the low-side interval. No output-voltage feedback is applied. The duty code and period are set from outside the block.

A digitised sense of the switching node passes through a two-flop synchronizer and then an edge detector. During the high-side interval, a rising node edge turns the high-side switch on. During the low-side interval, a falling node edge turns the low-side switch on. Under heavy load the inductor current may never reverse, so the node may never rise. A programmable fallback timer covers that case: it starts when the low-side enable drops, and when it expires it forces the high-side switch on. The node path and the timer path are ORed, and whichever fires first wins. A registered interlock keeps the two enables from ever being high together.

Top module: `zvs_gate_seq`

## Requirements
- R1: While `rstN` is low, `hsEn` and `lsEn` are both low and the slot counter sits at slot 0, so `pwmPhase` is low for any non-zero duty code. The fallback timer leaves reset already expired, so `hsEn` rises on the first rising clock edge after reset is released.
- R2: One period lasts 64*(`stepDiv`+1) clocks. Within it, `pwmPhase` is low for the first `dutyCode`*(`stepDiv`+1) clocks and high for the rest.
- R3: A duty code of 0 holds `pwmPhase` high at all times, and `hsEn` never asserts. A duty code of 63 gives 63 low slots out of 64.
- R4: `hsEn` goes low on the rising edge at the end of the first cycle in which `pwmPhase` is high.
- R5: `lsEn` can rise only while `pwmPhase` is high, only after a 1-to-0 transition of `nodeSense` seen in that interval, and only while `hsEn` is already low. A change of `nodeSense` made before a rising edge reaches `lsEn` on the third rising edge, counting that one.
- R6: `lsEn` goes low on the rising edge at the end of the first cycle in which `pwmPhase` is low, whatever the state of `nodeSense`.
- R7: `hsEn` rises during the low-phase interval after a 0-to-1 transition of `nodeSense` seen in that interval, with the same three-edge latency as R5. A rise seen while `lsEn` is still high is remembered and acted on once `lsEn` is low.
- R8: The fallback timer loads `fbDelay` on the edge where the low-side interval ends. If no node rise comes first, `hsEn` rises `fbDelay`+1 clocks after `lsEn` falls. A `fbDelay` of 0 turns the high side on in the cycle right after the low side turns off.
- R9: The node-rise path and the fallback path are ORed, and `hsEn` rises at whichever edge comes first.
- R10: `hsEn` and `lsEn` are never high in the same cycle.
- R11: Node edges outside their own interval are ignored. A fall during the low-phase interval does not enable `lsEn` in the following interval, and a rise during the high-phase interval does not speed up `hsEn` in the next low-phase interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dutyCode | input | 6 | Number of high-side slots per 64-slot period |
| stepDiv | input | 4 | Clocks per slot minus one |
| fbDelay | input | 6 | Fallback delay in clocks before a forced high-side turn-on |
| nodeSense | input | 1 | Asynchronous digitised switching-node level |
| hsEn | output | 1 | High-side switch enable |
| lsEn | output | 1 | Low-side switch enable |
| pwmPhase | output | 1 | Phase signal: low marks the high-side interval, high marks the low-side interval |

## Verification
Two functions can both try to turn the high side on in the same low-phase interval: the node-rise detector and the fallback timer. The bench sets up this race directly. It raises `nodeSense` on the very edge where the low-side interval ends, once with a zero fallback delay and once with a long one. It expects `hsEn` on exactly the second edge in the first case, where the timer wins, and on exactly the third edge in the second case, where the node path wins. A second collision comes from a late node rise that arrives while `lsEn` is still high. That rise must be held back, and the interlock must still keep the enables apart in every cycle.

// File: rtl/zvs_seq_pkg.sv
package zvs_seq_pkg;

  // Observations the datapath hands to the control each cycle
  typedef struct packed {
    logic pwmHigh;    // low-side interval in progress
    logic pwmEnd;     // first cycle of a high-side interval after a low-side one
    logic nodeRise;   // synchronized node went 0 -> 1
    logic nodeFall;   // synchronized node went 1 -> 0
    logic fbExpired;  // fallback delay has run out
  } dpStatus_t;

  // Strobes the control issues to the datapath
  typedef struct packed {
    logic fbLoad;     // reload the fallback timer
    logic fbClear;    // mark the fallback timer as not expired
  } ctrlStrobe_t;

endpackage

// File: rtl/zvs_node_sync.sv
module zvs_node_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic qOut
);

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[0] <= 1'b0;
        else       chain[0] <= dIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= 1'b0;
        else       chain[i] <= chain[i-1];
      end
    end
  end

  assign qOut = chain[STAGES-1];

endmodule

// File: rtl/zvs_datapath.sv
module zvs_datapath
  import zvs_seq_pkg::*;
#(
  parameter int DUTY_W      = 6,
  parameter int STEP_W      = 4,
  parameter int FB_W        = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DUTY_W-1:0] dutyCode,
  input  logic [STEP_W-1:0] stepDiv,
  input  logic [FB_W-1:0]   fbDelay,
  input  logic              nodeSense,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status
);

  // Slot timing: each slot is stepDiv+1 clocks, 2**DUTY_W slots per period
  logic [STEP_W-1:0] preCnt;
  logic [DUTY_W-1:0] slotCnt;
  logic              slotEnd;
  logic              pwmHigh;
  logic              pwmQ;

  assign slotEnd = (preCnt >= stepDiv);
  assign pwmHigh = (slotCnt >= dutyCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      slotCnt <= '0;
    end else if (slotEnd) begin
      preCnt  <= '0;
      slotCnt <= slotCnt + 1'b1;
    end else begin
      preCnt  <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwmQ <= 1'b0;
    else       pwmQ <= pwmHigh;
  end

  // Node sense: synchronizer, then one flop for edge detection
  logic nodeS;
  logic nodeQ;

  zvs_node_sync #(.STAGES(SYNC_STAGES)) nodeSync_i (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (nodeSense),
    .qOut (nodeS)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nodeQ <= 1'b0;
    else       nodeQ <= nodeS;
  end

  // Fallback timer: expired out of reset, reloaded at the end of each low-side interval
  logic [FB_W-1:0] fbCnt;
  logic            fbDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fbCnt  <= '0;
      fbDone <= 1'b1;
    end else if (strobe.fbLoad) begin
      fbCnt  <= fbDelay;
      fbDone <= (fbDelay == '0);
    end else if (strobe.fbClear) begin
      fbDone <= 1'b0;
    end else if (!fbDone) begin
      if (fbCnt <= FB_W'(1)) fbDone <= 1'b1;
      fbCnt <= (fbCnt == '0) ? '0 : fbCnt - 1'b1;
    end
  end

  always_comb begin
    status           = '0;
    status.pwmHigh   = pwmHigh;
    status.pwmEnd    = !pwmHigh && pwmQ;
    status.nodeRise  = nodeS && !nodeQ;
    status.nodeFall  = !nodeS && nodeQ;
    status.fbExpired = fbDone;
  end

endmodule

// File: rtl/zvs_control.sv
module zvs_control
  import zvs_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        hsEn,
  output logic        lsEn
);

  logic fellSeen;
  logic roseSeen;
  logic hsGo;
  logic lsGo;

  // Turn-on requests; each one is blocked while the opposite enable is high
  assign hsGo = !status.pwmHigh && (roseSeen || status.nodeRise || status.fbExpired) && !lsEn;
  assign lsGo =  status.pwmHigh && (fellSeen || status.nodeFall) && !hsEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsEn     <= 1'b0;
      lsEn     <= 1'b0;
      fellSeen <= 1'b0;
      roseSeen <= 1'b0;
    end else begin
      hsEn     <= status.pwmHigh ? 1'b0 : (hsEn || hsGo);
      lsEn     <= status.pwmHigh ? (lsEn || lsGo) : 1'b0;
      fellSeen <= status.pwmHigh && (fellSeen || status.nodeFall);
      roseSeen <= !status.pwmHigh && (roseSeen || status.nodeRise);
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.fbLoad  = status.pwmEnd;
    strobe.fbClear = status.pwmHigh;
  end

  // R10
  interlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hsEn && lsEn));

  // R4
  hs_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsEn && status.pwmHigh) |=> !hsEn);

  // R6
  ls_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lsEn && !status.pwmHigh) |=> !lsEn);

  // R7
  hs_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsEn) |-> (!$past(status.pwmHigh) && !$past(lsEn)));

  // R5
  ls_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsEn) |-> ($past(status.pwmHigh) && !$past(hsEn)));

endmodule

// File: rtl/zvs_gate_seq.sv
module zvs_gate_seq
  import zvs_seq_pkg::*;
#(
  parameter int DUTY_W      = 6,
  parameter int STEP_W      = 4,
  parameter int FB_W        = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DUTY_W-1:0] dutyCode,
  input  logic [STEP_W-1:0] stepDiv,
  input  logic [FB_W-1:0]   fbDelay,
  input  logic              nodeSense,
  output logic              hsEn,
  output logic              lsEn,
  output logic              pwmPhase
);

  dpStatus_t   status;
  ctrlStrobe_t strobe;

  zvs_datapath #(
    .DUTY_W      (DUTY_W),
    .STEP_W      (STEP_W),
    .FB_W        (FB_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .dutyCode  (dutyCode),
    .stepDiv   (stepDiv),
    .fbDelay   (fbDelay),
    .nodeSense (nodeSense),
    .strobe    (strobe),
    .status    (status)
  );

  zvs_control control_i (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .strobe (strobe),
    .hsEn   (hsEn),
    .lsEn   (lsEn)
  );

  assign pwmPhase = status.pwmHigh;

endmodule

// File: tb/zvs_gate_seq_tb_top.sv
`timescale 1ns/1ps
module zvs_gate_seq_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] dutyCode = 6'd20;
  logic [3:0] stepDiv = 4'd0;
  logic [5:0] fbDelay = 6'd0;
  logic       nodeSense = 1'b0;
  logic       hsEn, lsEn, pwmPhase;

  int checks = 0;
  int errors = 0;
  int overlapCnt = 0;

  // {duty, stepDiv, expected low clocks, expected period clocks}
  localparam int VT [0:4][0:3] = '{
    '{5,  0, 5,  64},
    '{32, 1, 64, 128},
    '{63, 0, 63, 64},
    '{1,  2, 3,  192},
    '{20, 3, 80, 256}
  };

  always #4 clk = ~clk;

  zvs_gate_seq dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .dutyCode  (dutyCode),
    .stepDiv   (stepDiv),
    .fbDelay   (fbDelay),
    .nodeSense (nodeSense),
    .hsEn      (hsEn),
    .lsEn      (lsEn),
    .pwmPhase  (pwmPhase)
  );

  always @(negedge clk) if (rstN && hsEn && lsEn) overlapCnt++;

  task automatic chkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitRise();
    logic prev, cur;
    cur = pwmPhase;
    do begin
      prev = cur;
      @(negedge clk);
      cur = pwmPhase;
    end while (!(!prev && cur));
  endtask

  task automatic waitFall();
    logic prev, cur;
    cur = pwmPhase;
    do begin
      prev = cur;
      @(negedge clk);
      cur = pwmPhase;
    end while (!(prev && !cur));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int bad;
    int lowCnt;
    int hiCnt;

    // R1 reset state
    repeat (3) @(negedge clk);
    chkEq("R1 enables low in reset", int'(hsEn) + int'(lsEn), 0);
    chkEq("R1 pwmPhase low in reset", int'(pwmPhase), 0);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1 hsEn on first edge after reset", int'(hsEn), 1);
    nodeSense = 1'b1;

    // R4 / R5: high side drops, node fall enables low side
    waitRise();
    chkEq("R4 hsEn still high in first pwm-high cycle", int'(hsEn), 1);
    nodeSense = 1'b0;
    fbDelay = 6'd63;
    @(negedge clk);
    chkEq("R4 hsEn low one cycle later", int'(hsEn), 0);
    @(negedge clk);
    chkEq("R5 lsEn not before third edge", int'(lsEn), 0);
    @(negedge clk);
    chkEq("R5 lsEn on third edge after node fall", int'(lsEn), 1);

    // R6 / R7 / R9: low side drops, node rise wins over long fallback
    waitFall();
    chkEq("R6 lsEn still high in first pwm-low cycle", int'(lsEn), 1);
    nodeSense = 1'b1;
    @(negedge clk);
    chkEq("R6 lsEn low one cycle later", int'(lsEn), 0);
    @(negedge clk);
    chkEq("R7 hsEn not before third edge", int'(hsEn), 0);
    @(negedge clk);
    chkEq("R9 R7 hsEn on third edge via node rise", int'(hsEn), 1);
    fbDelay = 6'd5;

    // R8: fallback with delay 5, node stays low
    waitRise();
    nodeSense = 1'b0;
    waitFall();
    bad = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (hsEn) bad++;
    end
    chkEq("R8 hsEn held off during fallback delay", bad, 0);
    @(negedge clk);
    chkEq("R8 hsEn forced after delay+1 clocks", int'(hsEn), 1);
    nodeSense = 1'b1;
    fbDelay = 6'd0;

    // R8 / R9: delay 0 fallback beats a simultaneous node rise
    waitRise();
    nodeSense = 1'b0;
    waitFall();
    nodeSense = 1'b1;
    @(negedge clk);
    chkEq("R8 hsEn off right after lsEn drops", int'(hsEn), 0);
    @(negedge clk);
    chkEq("R9 R8 zero-delay fallback wins", int'(hsEn), 1);
    nodeSense = 1'b0;
    fbDelay = 6'd8;

    // R11: out-of-interval edges ignored
    waitRise();
    bad = 0;
    hiCnt = 0;
    while (pwmPhase) begin
      if (lsEn) bad++;
      hiCnt++;
      if (hiCnt == 5) nodeSense = 1'b1;
      @(negedge clk);
    end
    chkEq("R11 lsEn never on after fall in low phase", bad, 0);
    bad = 0;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      if (hsEn) bad++;
    end
    chkEq("R11 rise in high phase not used", bad, 0);
    @(negedge clk);
    chkEq("R11 hsEn by fallback only", int'(hsEn), 1);

    // R3: duty 0
    dutyCode = 6'd0;
    repeat (3) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 200; k++) begin
      if (!pwmPhase || hsEn) bad++;
      @(negedge clk);
    end
    chkEq("R3 duty 0 keeps pwm high and hsEn off", bad, 0);

    // R2 / R3: period and duty table
    for (int v = 0; v < 5; v++) begin
      dutyCode = 6'(VT[v][0]);
      stepDiv  = 4'(VT[v][1]);
      waitFall();
      waitRise();
      waitFall();
      lowCnt = 1;
      @(negedge clk);
      while (!pwmPhase) begin
        lowCnt++;
        @(negedge clk);
      end
      hiCnt = 1;
      @(negedge clk);
      while (pwmPhase) begin
        hiCnt++;
        @(negedge clk);
      end
      chkEq($sformatf("R2 R3 low clocks entry %0d", v), lowCnt, VT[v][2]);
      chkEq($sformatf("R2 period clocks entry %0d", v), lowCnt + hiCnt, VT[v][3]);
    end

    chkEq("R10 enables never overlap", overlapCnt, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule